// File: doc/BRIEF.md
# Clock Set-Button Command Controller

This block turns two debounced set buttons (hours and minutes) into command strobes for the registers of a digital clock. The current display selection decides what the buttons mean. In time view and alarm view they advance the hour or minute field of the time or alarm register: one step at once, then, while the button stays down, repeated steps at the 2 Hz rate. In seconds view the hour button clears the seconds, with a carry into the minutes when the seconds had reached 50 or more. The minute button freezes the time counter for as long as it is held. Both buttons together reset the time to midnight. In alarm view both buttons together reset the alarm to midnight.

Resets and the hold are guarded by a lockout. Once either has been entered, every other button function is ignored until both buttons have been let go. Any fresh press also clears a pending power-failure indication. The time, alarm, seconds and sleep counters themselves sit outside this block. They act on the strobes and read the reset-format flag to load 12:00 or 0:00.

Top module: `clkset_ctrl`

## Requirements
- R1: After a synchronous reset, every output is low.
- R2: Display code `disp_mode` is 2'b00 for time, 2'b01 for alarm, 2'b10 for sleep and 2'b11 for seconds. In time view a rising button gives a one-cycle `time_hr_inc` or `time_mn_inc` in the cycle after the press. In alarm view it gives `alm_hr_inc` or `alm_mn_inc` instead.
- R3: While a button stays held, the first `tick_4hz` after the press arms auto-repeat. Each later `tick_2hz` then gives one more increment strobe, one cycle after the tick. A 2 Hz tick in the same cycle as the arming tick gives no strobe.
- R4: In time view, pressing both buttons together strobes both time increments in the same cycle.
- R5: In alarm view, holding both buttons gives one `alm_rst` strobe and no alarm increment. `rst_12h` is high with the strobe when `fmt_24h` is 0 and low when it is 1.
- R6: In seconds view, a press of the hour button gives one `sec_clr` strobe. `sec_carry` is high with it exactly when `sec_ge50` was high in the cycle of the press.
- R7: In seconds view, holding the minute button alone raises `time_hold` from the cycle after the press. It stays high until that button is released.
- R8: In seconds view, holding both buttons gives one `time_rst` strobe. `rst_12h` follows the same rule as in R5.
- R9: After a reset or hold has been entered, no increment, clear or reset strobe is issued until both buttons have been low for a cycle.
- R10: A rising edge on either button gives a one-cycle `pf_clr` in any view, lockout or not.
- R11: In sleep view the buttons issue no command to the time or alarm registers.
- R12: An hour press never strobes a minute increment, and a minute press never strobes an hour increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hr_btn | input | 1 | Debounced hour-set button level |
| mn_btn | input | 1 | Debounced minute-set button level |
| disp_mode | input | 2 | Display view: 00 time, 01 alarm, 10 sleep, 11 seconds |
| fmt_24h | input | 1 | 1 selects the 24-hour basis |
| sec_ge50 | input | 1 | Seconds counter currently shows 50 to 59 |
| tick_4hz | input | 1 | One-cycle pulse at 4 Hz |
| tick_2hz | input | 1 | One-cycle pulse at 2 Hz, coincident with every other 4 Hz pulse |
| time_hr_inc | output | 1 | Increment time hours |
| time_mn_inc | output | 1 | Increment time minutes |
| alm_hr_inc | output | 1 | Increment alarm hours |
| alm_mn_inc | output | 1 | Increment alarm minutes |
| sec_clr | output | 1 | Clear seconds to 00 |
| sec_carry | output | 1 | With sec_clr: also add one minute |
| time_hold | output | 1 | Freeze the time counter |
| time_rst | output | 1 | Reset time to midnight |
| alm_rst | output | 1 | Reset alarm to midnight |
| rst_12h | output | 1 | With a reset strobe: load 12:00 rather than 0:00 |
| pf_clr | output | 1 | Clear the power-failure indication |

## Verification
A wrong lockout state shows at the ports one cycle later. Either a strobe leaks out while both buttons are still held after a reset or hold, or a fresh press after release is swallowed. A stuck or early repeat-arm bit shows as an increment on the 2 Hz tick that shares a cycle with the arming tick, or as no increment on the tick after it. A wrong view decode sends a strobe to the wrong register in the cycle after the press. The directed scenarios look at each of these windows at the exact cycle.

// File: rtl/clkset_pkg.sv
// Package: shared types for the set-button controller.
// Assumes: display code bit0 is the alarm-view switch, bit1 the sleep-view
// switch; both closed select the seconds view.
package clkset_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        VIEW_TIME  = 2'b00,
        VIEW_ALARM = 2'b01,
        VIEW_SLEEP = 2'b10,
        VIEW_SECS  = 2'b11
    } view_e;

    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_HOLD = 2'd1,
        LK_RST  = 2'd2
    } lock_e;

    typedef struct packed {
        logic time_hr_inc;
        logic time_mn_inc;
        logic alm_hr_inc;
        logic alm_mn_inc;
        logic sec_clr;
        logic sec_carry;
        logic time_rst;
        logic alm_rst;
        logic rst_12h;
        logic pf_clr;
    } cmd_t;
endpackage

// File: rtl/clkset_btn.sv
// Module: per-button edge detect and auto-repeat timing.
// Assumes: btn is already debounced; tick_2hz pulses coincide with every
// other tick_4hz pulse. The first 4 Hz tick after a press arms the repeat,
// and 2 Hz ticks after that produce steps, giving a 1/4 to 3/4 s delay.
module clkset_btn (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    input  logic tick_4hz,
    input  logic tick_2hz,
    output logic press,
    output logic step
);
    logic prev_q;
    logic armed_q;

    // Remember the last button level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= btn;
    end

    // Arm the repeat on the first 4 Hz tick while held; drop it on release.
    always_ff @(posedge clk) begin
        if (!rst_n || !btn)   armed_q <= 1'b0;
        else if (tick_4hz)    armed_q <= 1'b1;
    end

    // Press is the rising edge; step is a repeat tick while armed and held.
    always_comb begin
        press = btn && !prev_q;
        step  = armed_q && tick_2hz && btn;
    end

    // R3
    step_not_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !press);
endmodule

// File: rtl/clkset_lock.sv
// Module: lockout state after a reset or hold has been entered.
// Assumes: set requests only arrive while a button is held, so release
// always wins when both buttons are low.
module clkset_lock
    import clkset_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hr_btn,
    input  logic  mn_btn,
    input  logic  set_rst,
    input  logic  set_hold,
    output lock_e lock_q
);
    // Enter lockout on request; leave it once both buttons are released.
    always_ff @(posedge clk) begin
        if (!rst_n)                lock_q <= LK_NONE;
        else if (!hr_btn && !mn_btn) lock_q <= LK_NONE;
        else if (set_rst)          lock_q <= LK_RST;
        else if (set_hold)         lock_q <= LK_HOLD;
    end

    // R9
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hr_btn && !mn_btn) |=> (lock_q == LK_NONE));
endmodule

// File: rtl/clkset_decode.sv
// Module: view-dependent meaning of the buttons (combinational).
// Assumes: inputs come from clkset_btn and clkset_lock; result is
// registered by the top level.
module clkset_decode
    import clkset_pkg::*;
(
    input  view_e view,
    input  logic  fmt_24h,
    input  logic  sec_ge50,
    input  logic  hr_btn,
    input  logic  mn_btn,
    input  logic  hr_press,
    input  logic  mn_press,
    input  logic  hr_step,
    input  logic  mn_step,
    input  lock_e lock_q,
    output cmd_t  cmd,
    output logic  set_rst,
    output logic  set_hold
);
    logic en, both, hr_adv, mn_adv;

    // Decode the next command word from view, buttons and lockout.
    always_comb begin
        en       = (lock_q == LK_NONE);
        both     = hr_btn && mn_btn;
        hr_adv   = en && (hr_press || hr_step);
        mn_adv   = en && (mn_press || mn_step);
        cmd      = '0;
        set_rst  = 1'b0;
        set_hold = 1'b0;
        cmd.pf_clr  = hr_press || mn_press;
        cmd.rst_12h = !fmt_24h;
        unique case (view)
            VIEW_TIME: begin
                cmd.time_hr_inc = hr_adv;
                cmd.time_mn_inc = mn_adv;
            end
            VIEW_ALARM: begin
                if (en && both) begin
                    cmd.alm_rst = 1'b1;
                    set_rst     = 1'b1;
                end else begin
                    cmd.alm_hr_inc = hr_adv;
                    cmd.alm_mn_inc = mn_adv;
                end
            end
            VIEW_SECS: begin
                if (en && both) begin
                    cmd.time_rst = 1'b1;
                    set_rst      = 1'b1;
                end else if (en && mn_btn && !hr_btn) begin
                    set_hold = 1'b1;
                end else begin
                    cmd.sec_clr   = en && hr_press;
                    cmd.sec_carry = en && hr_press && sec_ge50;
                end
            end
            default: ;
        endcase
        if (!cmd.time_rst && !cmd.alm_rst) cmd.rst_12h = 1'b0;
    end
endmodule

// File: rtl/clkset_ctrl.sv
// Module: top of the set-button command controller.
// Assumes: buttons are debounced levels; tick inputs are one-cycle pulses.
// Every command appears one cycle after the input event that causes it;
// time_hold follows the lockout state and the minute button directly.
module clkset_ctrl
    import clkset_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hr_btn,
    input  logic                mn_btn,
    input  logic [MODE_W-1:0]   disp_mode,
    input  logic                fmt_24h,
    input  logic                sec_ge50,
    input  logic                tick_4hz,
    input  logic                tick_2hz,
    output logic                time_hr_inc,
    output logic                time_mn_inc,
    output logic                alm_hr_inc,
    output logic                alm_mn_inc,
    output logic                sec_clr,
    output logic                sec_carry,
    output logic                time_hold,
    output logic                time_rst,
    output logic                alm_rst,
    output logic                rst_12h,
    output logic                pf_clr
);
    localparam int NBTN = 2;

    logic [NBTN-1:0] btn_lv, btn_press, btn_step;
    lock_e lock_q;
    cmd_t  cmd_d, cmd_q;
    logic  set_rst, set_hold;

    assign btn_lv = {mn_btn, hr_btn};

    // One edge/repeat tracker per set button.
    for (genvar i = 0; i < NBTN; i++) begin : g_btn
        clkset_btn u_btn (
            .clk      (clk),
            .rst_n    (rst_n),
            .btn      (btn_lv[i]),
            .tick_4hz (tick_4hz),
            .tick_2hz (tick_2hz),
            .press    (btn_press[i]),
            .step     (btn_step[i])
        );
    end

    clkset_decode u_dec (
        .view     (view_e'(disp_mode)),
        .fmt_24h  (fmt_24h),
        .sec_ge50 (sec_ge50),
        .hr_btn   (hr_btn),
        .mn_btn   (mn_btn),
        .hr_press (btn_press[0]),
        .mn_press (btn_press[1]),
        .hr_step  (btn_step[0]),
        .mn_step  (btn_step[1]),
        .lock_q   (lock_q),
        .cmd      (cmd_d),
        .set_rst  (set_rst),
        .set_hold (set_hold)
    );

    clkset_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .hr_btn   (hr_btn),
        .mn_btn   (mn_btn),
        .set_rst  (set_rst),
        .set_hold (set_hold),
        .lock_q   (lock_q)
    );

    // Register the command word so every strobe is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    // Drive the ports from the registered command and lockout.
    always_comb begin
        time_hr_inc = cmd_q.time_hr_inc;
        time_mn_inc = cmd_q.time_mn_inc;
        alm_hr_inc  = cmd_q.alm_hr_inc;
        alm_mn_inc  = cmd_q.alm_mn_inc;
        sec_clr     = cmd_q.sec_clr;
        sec_carry   = cmd_q.sec_carry;
        time_rst    = cmd_q.time_rst;
        alm_rst     = cmd_q.alm_rst;
        rst_12h     = cmd_q.rst_12h;
        pf_clr      = cmd_q.pf_clr;
        time_hold   = (lock_q == LK_HOLD) && mn_btn;
    end

    // R9
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != LK_NONE) |=> !(time_hr_inc || time_mn_inc || alm_hr_inc ||
                                  alm_mn_inc || sec_clr || time_rst || alm_rst));
    // R5
    rst_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_rst || alm_rst) |-> $past(hr_btn && mn_btn));
    // R10
    pf_needs_btn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_clr |-> $past(hr_btn || mn_btn));
    // R11
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({time_rst, alm_rst, sec_clr, alm_hr_inc || alm_mn_inc,
                  time_hr_inc || time_mn_inc}));
endmodule

// File: tb/clkset_ctrl_tb.sv
module clkset_ctrl_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic hr_btn = 0, mn_btn = 0, fmt_24h = 0, sec_ge50 = 0;
    logic tick_4hz = 0, tick_2hz = 0;
    logic [1:0] disp_mode = 2'b00;
    logic time_hr_inc, time_mn_inc, alm_hr_inc, alm_mn_inc, sec_clr, sec_carry;
    logic time_hold, time_rst, alm_rst, rst_12h, pf_clr;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    clkset_ctrl u_dut (.*);

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic any_cmd();
        return time_hr_inc | time_mn_inc | alm_hr_inc | alm_mn_inc |
               sec_clr | time_rst | alm_rst;
    endfunction

    task automatic release_all();
        hr_btn = 0; mn_btn = 0; cyc(2);
    endtask

    task automatic t_reset();
        cyc(3); rst_n = 1; cyc(1);
        chk(any_cmd() | time_hold | pf_clr | sec_carry | rst_12h, 1'b0, "R1 reset");
    endtask

    task automatic t_time_view();
        disp_mode = 2'b00; hr_btn = 1; cyc(1);
        chk(time_hr_inc, 1, "R2 time hr");
        chk(time_mn_inc, 0, "R12 no mn");
        chk(pf_clr, 1, "R10 pf");
        cyc(1);
        chk(time_hr_inc, 0, "R2 single strobe");
        tick_4hz = 1; tick_2hz = 1; cyc(1);
        tick_4hz = 0; tick_2hz = 0;
        chk(time_hr_inc, 0, "R3 no step on arming tick");
        tick_4hz = 1; tick_2hz = 1; cyc(1);
        tick_4hz = 0; tick_2hz = 0;
        chk(time_hr_inc, 1, "R3 repeat step");
        cyc(1);
        chk(time_hr_inc, 0, "R3 step ends");
        release_all();
        mn_btn = 1; cyc(1);
        chk(time_mn_inc, 1, "R2 time mn");
        chk(time_hr_inc, 0, "R12 no hr");
        tick_4hz = 1; cyc(1); tick_4hz = 0;
        chk(time_mn_inc, 0, "R3 4Hz only arms");
        tick_4hz = 1; tick_2hz = 1; cyc(1); tick_4hz = 0; tick_2hz = 0;
        chk(time_mn_inc, 1, "R3 next 2Hz steps");
        release_all();
        hr_btn = 1; mn_btn = 1; cyc(1);
        chk(time_hr_inc & time_mn_inc, 1, "R4 both advance");
        release_all();
    endtask

    task automatic t_alarm_view();
        disp_mode = 2'b01; fmt_24h = 0; hr_btn = 1; cyc(1);
        chk(alm_hr_inc, 1, "R2 alarm hr");
        chk(time_hr_inc, 0, "R2 not time");
        release_all();
        hr_btn = 1; mn_btn = 1; cyc(1);
        chk(alm_rst, 1, "R5 alarm reset");
        chk(rst_12h, 1, "R5 12h value");
        chk(alm_hr_inc | alm_mn_inc, 0, "R5 no inc");
        tick_4hz = 1; cyc(1); tick_4hz = 0;
        chk(alm_rst, 0, "R5 single reset");
        tick_4hz = 1; tick_2hz = 1; cyc(1); tick_4hz = 0; tick_2hz = 0;
        chk(alm_hr_inc | alm_mn_inc, 0, "R9 repeat locked");
        release_all();
        hr_btn = 1; cyc(1);
        chk(alm_hr_inc, 1, "R9 unlocked after release");
        release_all();
        fmt_24h = 1; hr_btn = 1; mn_btn = 1; cyc(1);
        chk(alm_rst, 1, "R5 reset 24h");
        chk(rst_12h, 0, "R5 24h value");
        release_all();
    endtask

    task automatic t_secs_view();
        disp_mode = 2'b11; sec_ge50 = 1; hr_btn = 1; cyc(1);
        chk(sec_clr, 1, "R6 clear");
        chk(sec_carry, 1, "R6 carry");
        release_all();
        sec_ge50 = 0; hr_btn = 1; cyc(1);
        chk(sec_clr, 1, "R6 clear 2");
        chk(sec_carry, 0, "R6 no carry");
        release_all();
        mn_btn = 1; cyc(1);
        chk(time_hold, 1, "R7 hold");
        hr_btn = 1; cyc(1);
        chk(time_rst | sec_clr, 0, "R9 locked by hold");
        mn_btn = 0; cyc(1);
        chk(time_hold, 0, "R7 hold released");
        release_all();
        fmt_24h = 0; hr_btn = 1; mn_btn = 1; cyc(1);
        chk(time_rst, 1, "R8 time reset");
        chk(rst_12h, 1, "R8 12h value");
        chk(time_hold, 0, "R9 no hold after reset");
        release_all();
    endtask

    task automatic t_sleep_view();
        disp_mode = 2'b10; hr_btn = 1; mn_btn = 1; cyc(1);
        chk(any_cmd() | time_hold, 0, "R11 sleep no cmd");
        chk(pf_clr, 1, "R10 pf in sleep");
        release_all();
    endtask

    initial begin
        t_reset();
        t_time_view();
        t_alarm_view();
        t_secs_view();
        t_sleep_view();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(20000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule